// File: doc/BRIEF.md
# PRBS/QRSS Pattern Tester

A per-channel maintenance block that produces a test pattern for the transmit direction and checks a pattern on the receive direction. It has two modes. In E1 mode the pattern is a 2^15-1 pseudo-random sequence. In T1/J1 mode it is a 2^20-1 quasi-random signal, with its zero runs limited to 14. Both the generator and the checker move one bit on each cycle in which the bit clock enable is high.

When the generator is switched on, its bit replaces the transmit data. The checker takes the received bits into its reference register while it is hunting. After 32 consecutive correct predictions it declares sync and runs on its own predictions. It drops sync when one of its fixed 64-bit windows collects six errors.

A 16-bit saturating counter accumulates one of two event sources, picked by a select input: pattern errors seen while in sync, or line-code violation pulses. A latch strobe copies the running count to the count output and restarts counting.

Top module: `ptst_top`

## Requirements
- R1: With `mode_i`=0 (E1) and the generator on, each enabled cycle emits b[n] = b[n-15] XOR b[n-14]. Reset treats every earlier bit as 1, so the first emitted bit is 0. The generator state is never all zero.
- R2: With `mode_i`=1 (T1/J1), the raw sequence is r[n] = r[n-20] XOR r[n-17], with earlier bits 1 after reset. The emitted bit is 1 whenever r[n-1]..r[n-14] are all zero, and r[n] otherwise. Bit 14 after reset is therefore a forced 1, and no run of zeros is longer than 14.
- R3: While `gen_en_i`=0, `tx_data_o` equals `tx_data_i` and the generator state holds. After re-enabling, the sequence resumes where it stopped.
- R4: In E1 mode the emitted sequence repeats with a period of 32767 bits.
- R5: The checker starts from reset state all ones, the same as the generator. It raises `sync_o` after 32 consecutive correctly predicted bits: with a clean looped-back stream, `sync_o` is 0 after bit 30 and 1 after bit 31 (bits counted from 0).
- R6: While in sync, errors are counted within fixed 64-bit windows whose first window starts with the bit after sync is acquired. `sync_o` falls right after the bit that brings a window's count to 6. Five errors in one window, or errors split across two windows, leave it high.
- R7: Only mismatches seen while `sync_o` is high count as pattern errors. A stream that never reaches sync adds nothing to the count.
- R8: An all-zero received stream never produces sync in either mode.
- R9: With `cnt_sel_i`=1 the counter counts cycles with `lcv_i`=1 and `ce_i`=1. With `cnt_sel_i`=0 the `lcv_i` input is ignored.
- R10: On `latch_i`, `cnt_o` takes the count accumulated since the previous latch (0 after reset), and the running count restarts.
- R11: The running count saturates at 0xFFFF.
- R12: Driving `chk_en_i` low clears `sync_o` at the next clock edge and returns the checker to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 1 | Bit clock enable; one pattern bit per enabled cycle |
| mode_i | input | 1 | 0 = E1 (2^15-1), 1 = T1/J1 (2^20-1 zero-limited) |
| gen_en_i | input | 1 | Put the generator bit on the transmit output |
| tx_data_i | input | 1 | Normal transmit bit |
| tx_data_o | output | 1 | Transmit bit after the pattern switch |
| chk_en_i | input | 1 | Checker enable |
| rx_data_i | input | 1 | Received bit |
| sync_o | output | 1 | Checker is locked to the pattern |
| cnt_sel_i | input | 1 | Counter source: 0 = pattern errors, 1 = line-code violations |
| lcv_i | input | 1 | Line-code violation pulse |
| latch_i | input | 1 | Copy the count to `cnt_o` and restart it |
| cnt_o | output | 16 | Count latched at the last strobe |

## Verification
The bench uses the default parameters: a 32-bit sync run, 64-bit windows, a loss threshold of six and a 16-bit counter. At these values a complete E1 period of 32767 bits can be compared bit by bit against an arithmetic model, and the counter can be driven all the way to saturation. In loopback, errors are injected at bit positions chosen relative to the known moment of sync acquisition, which sets the window boundaries. This covers the exact cycle of acquisition, errors split across a window boundary, the sixth-error loss and the exact cycle of re-acquisition, all in both modes.

// File: rtl/ptst_pkg.sv
// Shared constants and pattern arithmetic for the PRBS/QRSS tester.
// Assumes state bit 0 holds the most recent raw bit.
package ptst_pkg;
    localparam int PRBS_N    = 15;   // E1 register length
    localparam int PRBS_T    = 14;   // E1 second tap
    localparam int QRSS_N    = 20;   // T1/J1 register length
    localparam int QRSS_T    = 17;   // T1/J1 second tap
    localparam int QRSS_ZMAX = 14;   // longest allowed zero run
    localparam int ST_W      = QRSS_N;

    typedef enum logic {PAT_E1 = 1'b0, PAT_T1 = 1'b1} pat_mode_e;

    // Next raw sequence bit from the history register.
    function automatic logic pat_raw(input logic [ST_W-1:0] s, input logic t1);
        return t1 ? (s[QRSS_N-1] ^ s[QRSS_T-1]) : (s[PRBS_N-1] ^ s[PRBS_T-1]);
    endfunction

    // True when the zero-run limit forces the emitted bit to one.
    function automatic logic pat_force(input logic [ST_W-1:0] s, input logic t1);
        return t1 && (s[QRSS_ZMAX-1:0] == '0);
    endfunction

    // True when the active part of the register is all zero.
    function automatic logic pat_zero(input logic [ST_W-1:0] s, input logic t1);
        return t1 ? (s[QRSS_N-1:0] == '0) : (s[PRBS_N-1:0] == '0);
    endfunction
endpackage

// File: rtl/ptst_gen.sv
// Pattern generator: steps one bit per enabled cycle and emits the
// (zero-limited in T1 mode) pattern bit. Assumes the mode is static
// while running; an all-zero active state is replaced by all ones.
module ptst_gen
    import ptst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic en,
    input  logic t1,
    output logic bit_o
);
    logic [ST_W-1:0] st_q;
    logic            raw;

    // Raw and emitted bits from the current history.
    always_comb begin
        raw   = pat_raw(st_q, t1);
        bit_o = raw | pat_force(st_q, t1);
    end

    // History register update with an all-zero guard.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '1;
        else if (ce && en) begin
            if (pat_zero(st_q, t1))
                st_q <= '1;
            else
                st_q <= {st_q[ST_W-2:0], raw};
        end
    end

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && en) |=> !pat_zero(st_q, $past(t1)));                      // R1
    AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce && en) |=> $stable(st_q));                                  // R3
endmodule

// File: rtl/ptst_chk.sv
// Pattern checker: hunts by loading received bits, locks after a run
// of correct predictions, then free-runs and drops lock when a fixed
// window collects too many errors. Assumes the mode is static.
module ptst_chk
    import ptst_pkg::*;
#(
    parameter int SYNC_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic en,
    input  logic t1,
    input  logic rx,
    output logic sync_o,
    output logic err_o
);
    localparam int RUN_W = $clog2(SYNC_RUN);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int WE_W  = $clog2(LOSS_ERRS + 1);

    logic [ST_W-1:0]  ref_q;
    logic             sync_q;
    logic [RUN_W-1:0] run_q;
    logic [WIN_W-1:0] win_q;
    logic [WE_W-1:0]  werr_q;
    logic             raw, frc, miss, refz, load_b;
    logic [WE_W-1:0]  werr_nx;

    // Prediction, mismatch and the bit to load while hunting.
    always_comb begin
        raw     = pat_raw(ref_q, t1);
        frc     = pat_force(ref_q, t1);
        miss    = rx ^ (raw | frc);
        refz    = pat_zero(ref_q, t1);
        load_b  = (frc && rx) ? raw : rx;
        werr_nx = werr_q + WE_W'(miss);
    end

    // Hunt / lock state machine with windowed error tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '1;
            sync_q <= 1'b0;
            run_q  <= '0;
            win_q  <= '0;
            werr_q <= '0;
        end else if (!en) begin
            sync_q <= 1'b0;
            run_q  <= '0;
            win_q  <= '0;
            werr_q <= '0;
        end else if (ce) begin
            if (!sync_q) begin
                ref_q <= {ref_q[ST_W-2:0], load_b};
                if (miss || refz)
                    run_q <= '0;
                else if (run_q == RUN_W'(SYNC_RUN - 1)) begin
                    sync_q <= 1'b1;
                    run_q  <= '0;
                    win_q  <= '0;
                    werr_q <= '0;
                end else
                    run_q <= run_q + 1'b1;
            end else begin
                ref_q <= {ref_q[ST_W-2:0], raw};
                if (werr_nx >= WE_W'(LOSS_ERRS)) begin
                    sync_q <= 1'b0;
                    run_q  <= '0;
                    win_q  <= '0;
                    werr_q <= '0;
                end else if (win_q == WIN_W'(WIN_LEN - 1)) begin
                    win_q  <= '0;
                    werr_q <= '0;
                end else begin
                    win_q  <= win_q + 1'b1;
                    werr_q <= werr_nx;
                end
            end
        end
    end

    assign sync_o = sync_q;
    assign err_o  = en && ce && sync_q && miss;

    AST_SYNC_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |-> ($past(run_q) == RUN_W'(SYNC_RUN - 1)));       // R5
    AST_SYNC_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_q) && $past(en)) |-> ($past(werr_q) == WE_W'(LOSS_ERRS - 1))); // R6
    AST_CHK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sync_q);                                                // R12
    AST_ZERO_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_q && refz) |=> !sync_q);                                  // R8
endmodule

// File: rtl/ptst_cnt.sv
// Saturating event counter with latch-and-restart. Assumes one event
// at most per cycle.
module ptst_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             latch,
    output logic [CNT_W-1:0] hold_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hold_q;

    // Running count, saturating, restarted by the latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (latch) begin
            hold_q <= cnt_q;
            cnt_q  <= CNT_W'(inc);
        end else if (inc && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign hold_o = hold_q;

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !latch) |=> (cnt_q == CNT_MAX));            // R11
    AST_LATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (cnt_q <= CNT_W'(1)));                                 // R10
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(hold_q));                                     // R10
endmodule

// File: rtl/ptst_top.sv
// PRBS/QRSS pattern tester top: generator with transmit switch,
// self-synchronising checker and a shared saturating error counter.
module ptst_top
    import ptst_pkg::*;
#(
    parameter int SYNC_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 6,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic             mode_i,
    input  logic             gen_en_i,
    input  logic             tx_data_i,
    output logic             tx_data_o,
    input  logic             chk_en_i,
    input  logic             rx_data_i,
    output logic             sync_o,
    input  logic             cnt_sel_i,
    input  logic             lcv_i,
    input  logic             latch_i,
    output logic [CNT_W-1:0] cnt_o
);
    pat_mode_e mode;
    logic      t1, gen_bit, pat_err, cnt_inc;

    // Mode decode and counter source select.
    always_comb begin
        mode    = pat_mode_e'(mode_i);
        t1      = (mode == PAT_T1);
        cnt_inc = cnt_sel_i ? (lcv_i && ce_i) : pat_err;
    end

    assign tx_data_o = gen_en_i ? gen_bit : tx_data_i;

    ptst_gen u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce_i),
        .en    (gen_en_i),
        .t1    (t1),
        .bit_o (gen_bit)
    );

    ptst_chk #(
        .SYNC_RUN  (SYNC_RUN),
        .WIN_LEN   (WIN_LEN),
        .LOSS_ERRS (LOSS_ERRS)
    ) u_chk (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (ce_i),
        .en     (chk_en_i),
        .t1     (t1),
        .rx     (rx_data_i),
        .sync_o (sync_o),
        .err_o  (pat_err)
    );

    ptst_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (cnt_inc),
        .latch  (latch_i),
        .hold_o (cnt_o)
    );
endmodule

// File: tb/ptst_top_bench.sv
// Loopback bench for the pattern tester with an arithmetic sequence model.
module ptst_top_bench;
    localparam int EN = 32767 + 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_i = 0, mode_i = 0, gen_en_i = 0, tx_data_i = 0, chk_en_i = 0;
    logic cnt_sel_i = 0, lcv_i = 0, latch_i = 0, flip = 0;
    logic tx_data_o, sync_o, rx_data_i;
    logic [15:0] cnt_o;

    int checks = 0, errors = 0;
    int bitn = 0, gen_mis = 0;
    bit done = 0;
    bit sync_seen;
    logic last_tx;
    bit raw_m [0:EN+19];
    bit mtx   [0:EN-1];
    bit rtl_b [0:EN-1];

    always #10 clk = ~clk;

    assign rx_data_i = tx_data_o ^ flip;

    ptst_top u_ptst_top (
        .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .mode_i(mode_i),
        .gen_en_i(gen_en_i), .tx_data_i(tx_data_i), .tx_data_o(tx_data_o),
        .chk_en_i(chk_en_i), .rx_data_i(rx_data_i), .sync_o(sync_o),
        .cnt_sel_i(cnt_sel_i), .lcv_i(lcv_i), .latch_i(latch_i), .cnt_o(cnt_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sequence model per R1/R2: index i = n + 20, earlier bits all one.
    task automatic build_model(input bit t1);
        for (int i = 0; i < 20; i++) raw_m[i] = 1'b1;
        for (int n = 0; n < EN; n++) begin
            bit z;
            raw_m[n+20] = t1 ? (raw_m[n] ^ raw_m[n+3]) : (raw_m[n+5] ^ raw_m[n+6]);
            z = 1'b1;
            for (int k = 6; k < 20; k++) if (raw_m[n+k]) z = 1'b0;
            mtx[n] = raw_m[n+20] | (t1 & z);
        end
    endtask

    task automatic reset_dut(input bit t1);
        rst_n = 0; mode_i = t1; ce_i = 0; gen_en_i = 0; tx_data_i = 0;
        chk_en_i = 0; cnt_sel_i = 0; lcv_i = 0; latch_i = 0; flip = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        bitn = 0; gen_mis = 0; sync_seen = 0;
    endtask

    // One enabled bit; optionally compares the generator output to the model.
    task automatic run_bit(input logic f, input bit gen_chk);
        @(negedge clk);
        ce_i = 1; flip = f;
        last_tx = tx_data_o;
        if (gen_chk) begin
            rtl_b[bitn] = tx_data_o;
            if (tx_data_o !== mtx[bitn]) gen_mis++;
            bitn++;
        end
        @(posedge clk);
        #2 ce_i = 0; flip = 0;
        if (sync_o) sync_seen = 1;
    endtask

    task automatic do_latch();
        @(negedge clk);
        latch_i = 1;
        @(posedge clk);
        #2 latch_i = 0;
    endtask

    function automatic bit inj(input int n);
        return (n == 40 || n == 50 || n == 60 || n == 70 || n == 80 ||
                (n >= 157 && n <= 162) || (n >= 230 && n <= 235));
    endfunction

    task automatic run_mode(input bit t1);
        string rq;
        int last;
        rq = t1 ? "R2" : "R1";
        build_model(t1);
        // R7: never-locked stream adds nothing to the count
        reset_dut(t1);
        chk_en_i = 1;
        for (int n = 0; n < 100; n++) begin
            tx_data_i = n[0];
            run_bit(1'b0, 1'b0);
        end
        check(!sync_seen, "R7 no sync on alternating data", int'(sync_seen), 0);
        do_latch();
        check(cnt_o == 16'd0, "R7 hunt mismatches not counted", int'(cnt_o), 0);
        // R8: all-zero stream never locks
        reset_dut(t1);
        chk_en_i = 1; tx_data_i = 0;
        for (int n = 0; n < 100; n++) run_bit(1'b0, 1'b0);
        check(!sync_seen, "R8 all-zero stream", int'(sync_seen), 0);
        // Main loopback scenario
        reset_dut(t1);
        check(sync_o == 1'b0, "R5 reset sync", int'(sync_o), 0);
        check(cnt_o == 16'd0, "R10 reset count", int'(cnt_o), 0);
        gen_en_i = 1; chk_en_i = 1;
        for (int n = 0; n < 272; n++) begin
            run_bit(inj(n), 1'b1);
            case (n)
                30:  check(sync_o == 1'b0, "R5 no sync after 31 bits", int'(sync_o), 0);
                31:  check(sync_o == 1'b1, "R5 sync after 32 bits", int'(sync_o), 1);
                95:  check(sync_o == 1'b1, "R6 five errors keep sync", int'(sync_o), 1);
                163: check(sync_o == 1'b1, "R6 errors split over windows", int'(sync_o), 1);
                234: check(sync_o == 1'b1, "R6 sync before sixth error", int'(sync_o), 1);
                235: check(sync_o == 1'b0, "R6 sync lost at sixth error", int'(sync_o), 0);
                266: check(sync_o == 1'b0, "R5 still hunting", int'(sync_o), 0);
                267: check(sync_o == 1'b1, "R5 re-acquired", int'(sync_o), 1);
                default: ;
            endcase
        end
        chk_en_i = 0;
        run_bit(1'b0, 1'b1);
        check(sync_o == 1'b0, "R12 checker disable clears sync", int'(sync_o), 0);
        do_latch();
        check(cnt_o == 16'd17, "R7 in-sync errors counted", int'(cnt_o), 17);
        do_latch();
        check(cnt_o == 16'd0, "R10 count restarted by latch", int'(cnt_o), 0);
        // R3: pass-through, generator holds
        gen_en_i = 0;
        for (int k = 0; k < 4; k++) begin
            tx_data_i = (k != 1);
            run_bit(1'b0, 1'b0);
            check(last_tx == tx_data_i, "R3 pass-through", int'(last_tx), int'(tx_data_i));
        end
        gen_en_i = 1;
        last = t1 ? 400 : EN;
        while (bitn < last) run_bit(1'b0, 1'b1);
        check(gen_mis == 0, {rq, " generator stream and R3 resume"}, gen_mis, 0);
        if (t1) begin
            int run, mx;
            run = 0; mx = 0;
            for (int n = 0; n < 400; n++) begin
                run = rtl_b[n] ? 0 : run + 1;
                if (run > mx) mx = run;
            end
            check(rtl_b[14] == 1'b1, "R2 forced one at bit 14", int'(rtl_b[14]), 1);
            check(mx <= 14, "R2 zero run limit", mx, 14);
        end else begin
            int pm;
            pm = 0;
            for (int n = 32767; n < EN; n++) if (rtl_b[n] != rtl_b[n-32767]) pm++;
            check(pm == 0, "R4 period 32767", pm, 0);
        end
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        // R9: line-code source
        reset_dut(1'b0);
        cnt_sel_i = 1;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk); ce_i = 1; lcv_i = 1;
            @(posedge clk);
        end
        #2 ce_i = 0; lcv_i = 0;
        do_latch();
        check(cnt_o == 16'd10, "R9 line-code events counted", int'(cnt_o), 10);
        cnt_sel_i = 0;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk); ce_i = 1; lcv_i = 1;
            @(posedge clk);
        end
        #2 ce_i = 0; lcv_i = 0;
        do_latch();
        check(cnt_o == 16'd0, "R9 line-code ignored when deselected", int'(cnt_o), 0);
        // R11: saturation
        cnt_sel_i = 1;
        for (int n = 0; n < 65540; n++) begin
            @(negedge clk); ce_i = 1; lcv_i = 1;
            @(posedge clk);
        end
        #2 ce_i = 0; lcv_i = 0;
        do_latch();
        check(cnt_o == 16'hFFFF, "R11 saturation", int'(cnt_o), 65535);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule